// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is the slave side of a serial memory reached over a four-wire SPI link plus a hold line and a write-protect line. It decodes a one-byte command at the start of every chip-select frame. It keeps a small status register with write-protect fields, gates array writes behind a write-enable latch, and streams array reads and writes byte after byte at bus speed. There is no page buffer and no busy period, so a single enabled write command may carry any number of data bytes.

All pins are sampled by the system clock through a synchronizer. Bits travel most significant first. The slave samples SI on rising SCK and changes SO on falling SCK, which serves both mode 0 (SCK idle low) and mode 3 (SCK idle high). After reset the slave ignores chip select for a parameterised number of clock cycles, and it then waits for chip select to be seen high before it honours a frame.

The address counter is `ADDR_W` bits wide (15 by default, giving 32 KiB). The storage model holds 2^`MEM_AW` bytes and repeats across the address space. Set `MEM_AW` equal to `ADDR_W` to build the full array.

Top module: `sermem_spi_slave`

## Requirements
- R1: After reset `spi_so_oe` is 0, and the first status read after power-up returns 0x00.
- R2: During the first `PWRUP_CYCLES` clock cycles after reset the slave ignores chip select: `spi_so_oe` stays 0 and commands have no effect.
- R3: Bytes are shifted MSB first. SI is sampled on rising SCK and SO changes on falling SCK. A frame may start with SCK low (mode 0) or high (mode 3), and in mode 3 the first falling edge is ignored.
- R4: A write-array command (0x02) or write-status command (0x01) received while the write-enable latch is clear has no effect for the rest of the frame.
- R5: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch also clears when chip select rises to end an accepted 0x02 or 0x01 frame.
- R6: Read-status (0x05) returns exactly one byte laid out as bit 7 = write-protect enable, bits 3:2 = protect field, bit 1 = write-enable latch, all other bits 0. Later bytes in the same frame read 0x00.
- R7: Read (0x03) and write (0x02) take a 16-bit address, high byte first. Address bit 15 is ignored.
- R8: The address advances by one after each data byte for as long as chip select stays low, with no page limit, and wraps from 0x7FFF to 0x0000.
- R9: Writes to protected addresses are dropped while the address still advances. Protect field 01 covers the top quarter (A14:A13 = 11), 10 covers the top half (A14 = 1), and 11 covers the whole array.
- R10: When status bit 7 is 1 and `spi_wp_n` is low, a write-status command leaves the status fields unchanged.
- R11: While `spi_hold_n` is low, SCK edges are ignored and `spi_so_oe` is 0. The transfer resumes unchanged after release.
- R12: Unknown opcodes make the slave ignore every remaining byte until chip select rises.
- R13: `spi_so_oe` is 1 only while chip select is low, hold is high and the slave is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause |
| spi_wp_n | input | 1 | Active-low write-protect pin |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for SO; 0 means high impedance |

## Verification
The assertions assume that every SCK, CS, SI and HOLD level stays stable for longer than the synchronizer depth plus one clock. They also assume that HOLD changes only when the frame is between bytes, and that CS rises only with SCK at its idle level. The bench holds each SCK phase for six clocks and sets SI together with the falling SCK. It applies HOLD only after a completed byte, with SCK high, and toggles SCK only while HOLD is low. Random frames pick mode 0 or mode 3, a 16-bit address, a burst length and whether to send the write-enable opcode first.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

   typedef enum logic [7:0] {
      OP_WRSR  = 8'h01,
      OP_WRITE = 8'h02,
      OP_READ  = 8'h03,
      OP_WRDI  = 8'h04,
      OP_RDSR  = 8'h05,
      OP_WREN  = 8'h06
   } opcode_e;

   typedef enum logic [2:0] {
      PH_OPCODE,
      PH_ADDR_HI,
      PH_ADDR_LO,
      PH_WRITE,
      PH_READ,
      PH_STAT_RD,
      PH_STAT_WR,
      PH_SKIP
   } phase_e;

   // protect field against the top two address bits (R9)
   function automatic logic addr_locked(input logic [1:0] bp, input logic [1:0] top2);
      case (bp)
         2'b01:   addr_locked = (top2 == 2'b11);
         2'b10:   addr_locked = top2[1];
         2'b11:   addr_locked = 1'b1;
         default: addr_locked = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/sermem_pin_sync.sv
module sermem_pin_sync #(
   parameter int           W       = 5,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], din};
   end

   assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sermem_pwrup.sv
module sermem_pwrup #(
   parameter int CYCLES = 2000
) (
   input  logic clk,
   input  logic rst_n,
   output logic ready
);
   localparam int CW = $clog2(CYCLES + 2);
   localparam logic [CW-1:0] LAST = CW'(CYCLES);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign ready = (cnt == LAST);
endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/sermem_engine.sv
module sermem_engine
   import sermem_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int MEM_AW = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_n_s,
   input  logic              si_s,
   input  logic              hold_n_s,
   input  logic              wp_n_s,
   input  logic              ready,
   input  logic [7:0]        mem_rdata,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_waddr,
   output logic [MEM_AW-1:0] mem_raddr,
   output logic [7:0]        mem_wdata,
   output logic              so_o,
   output logic              so_oe,
   output logic              wel_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [2:0]        bitcnt_o
);
   logic              sck_d, armed, seen_rise, load_pend, clr_pend, is_read;
   logic              wel, wpen;
   logic [1:0]        bp;
   logic [2:0]        bit_cnt;
   logic [6:0]        rx_sr;
   logic [7:0]        tx_sr, tx_load;
   logic [ADDR_W-1:0] addr_q;
   phase_e            phase;

   logic              sel, live, rise, fall, byte_done, wp_lock;
   logic [7:0]        rx_byte, status;
   logic [ADDR_W-1:0] cur_addr;

   always_comb begin
      sel       = armed & ~cs_n_s;
      live      = sel & hold_n_s;
      rise      = live & sck_s & ~sck_d;
      fall      = live & ~sck_s & sck_d & seen_rise;
      byte_done = rise & (bit_cnt == 3'd7);
      rx_byte   = {rx_sr, si_s};
      status    = {wpen, 3'b000, bp, wel, 1'b0};
      wp_lock   = wpen & ~wp_n_s;
      cur_addr  = (phase == PH_ADDR_LO) ? {addr_q[ADDR_W-1:8], rx_byte} : addr_q;
   end

   assign mem_raddr = cur_addr[MEM_AW-1:0];
   assign mem_waddr = addr_q[MEM_AW-1:0];
   assign mem_wdata = rx_byte;
   assign mem_we    = byte_done & (phase == PH_WRITE) & ~addr_locked(bp, addr_q[ADDR_W-1 -: 2]);
   assign so_o      = tx_sr[7];
   assign so_oe     = live;
   assign wel_o     = wel;
   assign addr_o    = addr_q;
   assign bitcnt_o  = bit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d     <= 1'b0;
         armed     <= 1'b0;
         seen_rise <= 1'b0;
         load_pend <= 1'b0;
         clr_pend  <= 1'b0;
         is_read   <= 1'b0;
         wel       <= 1'b0;
         wpen      <= 1'b0;
         bp        <= 2'b00;
         bit_cnt   <= 3'd0;
         rx_sr     <= 7'd0;
         tx_sr     <= 8'd0;
         tx_load   <= 8'd0;
         addr_q    <= '0;
         phase     <= PH_OPCODE;
      end else begin
         sck_d <= sck_s;
         if (!ready)      armed <= 1'b0;
         else if (cs_n_s) armed <= 1'b1;

         if (!sel) begin
            bit_cnt   <= 3'd0;
            phase     <= PH_OPCODE;
            seen_rise <= 1'b0;
            load_pend <= 1'b0;
            tx_sr     <= 8'd0;
            clr_pend  <= 1'b0;
            if (clr_pend) wel <= 1'b0;
         end else begin
            if (rise) begin
               rx_sr     <= rx_byte[6:0];
               bit_cnt   <= bit_cnt + 3'd1;
               seen_rise <= 1'b1;
            end
            if (fall) begin
               if (load_pend) begin
                  tx_sr     <= tx_load;
                  load_pend <= 1'b0;
               end else begin
                  tx_sr <= {tx_sr[6:0], 1'b0};
               end
            end
            if (byte_done) begin
               case (phase)
                  PH_OPCODE: begin
                     phase <= PH_SKIP;
                     case (rx_byte)
                        OP_WREN: wel <= 1'b1;
                        OP_WRDI: wel <= 1'b0;
                        OP_RDSR: begin
                           tx_load   <= status;
                           load_pend <= 1'b1;
                           phase     <= PH_STAT_RD;
                        end
                        OP_WRSR: if (wel) begin
                           clr_pend <= 1'b1;
                           phase    <= PH_STAT_WR;
                        end
                        OP_READ: begin
                           is_read <= 1'b1;
                           phase   <= PH_ADDR_HI;
                        end
                        OP_WRITE: if (wel) begin
                           is_read  <= 1'b0;
                           clr_pend <= 1'b1;
                           phase    <= PH_ADDR_HI;
                        end
                        default: ;
                     endcase
                  end
                  PH_ADDR_HI: begin
                     addr_q[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
                     phase              <= PH_ADDR_LO;
                  end
                  PH_ADDR_LO: begin
                     if (is_read) begin
                        addr_q    <= cur_addr + 1'b1;
                        tx_load   <= mem_rdata;
                        load_pend <= 1'b1;
                        phase     <= PH_READ;
                     end else begin
                        addr_q <= cur_addr;
                        phase  <= PH_WRITE;
                     end
                  end
                  PH_READ: begin
                     addr_q    <= addr_q + 1'b1;
                     tx_load   <= mem_rdata;
                     load_pend <= 1'b1;
                  end
                  PH_WRITE:   addr_q <= addr_q + 1'b1;
                  PH_STAT_RD: phase <= PH_SKIP;
                  PH_STAT_WR: begin
                     if (!wp_lock) begin
                        wpen <= rx_byte[7];
                        bp   <= rx_byte[3:2];
                     end
                     phase <= PH_SKIP;
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/sermem_spi_slave.sv
module sermem_spi_slave #(
   parameter int ADDR_W       = 15,
   parameter int MEM_AW       = 12,
   parameter int SYNC_STAGES  = 2,
   parameter int PWRUP_CYCLES = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_si,
   input  logic spi_hold_n,
   input  logic spi_wp_n,
   output logic spi_so,
   output logic spi_so_oe
);
   localparam int         PIN_N   = 5;
   localparam logic [4:0] PIN_RST = 5'b11010; // wp, hold, si, cs, sck

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
      $error("ADDR_W must lie in 9..16");
   end
   if (MEM_AW < 1 || MEM_AW > ADDR_W) begin : g_bad_mem_aw
      $error("MEM_AW must lie in 1..ADDR_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [PIN_N-1:0]  pins_s;
   logic              sck_s, cs_n_s, si_s, hold_n_s, wp_n_s, ready;
   logic              mem_we, wel_dbg;
   logic [MEM_AW-1:0] mem_waddr, mem_raddr;
   logic [7:0]        mem_wdata, mem_rdata;
   logic [ADDR_W-1:0] addr_dbg;
   logic [2:0]        bitcnt_dbg;

   sermem_pin_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_wp_n, spi_hold_n, spi_si, spi_cs_n, spi_sck}),
      .dout (pins_s)
   );
   assign {wp_n_s, hold_n_s, si_s, cs_n_s, sck_s} = pins_s;

   sermem_pwrup #(.CYCLES(PWRUP_CYCLES)) u_pwrup (
      .clk  (clk),
      .rst_n(rst_n),
      .ready(ready)
   );

   sermem_array #(.AW(MEM_AW)) u_array (
      .clk  (clk),
      .we   (mem_we),
      .waddr(mem_waddr),
      .wdata(mem_wdata),
      .raddr(mem_raddr),
      .rdata(mem_rdata)
   );

   sermem_engine #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_s    (sck_s),
      .cs_n_s   (cs_n_s),
      .si_s     (si_s),
      .hold_n_s (hold_n_s),
      .wp_n_s   (wp_n_s),
      .ready    (ready),
      .mem_rdata(mem_rdata),
      .mem_we   (mem_we),
      .mem_waddr(mem_waddr),
      .mem_raddr(mem_raddr),
      .mem_wdata(mem_wdata),
      .so_o     (spi_so),
      .so_oe    (spi_so_oe),
      .wel_o    (wel_dbg),
      .addr_o   (addr_dbg),
      .bitcnt_o (bitcnt_dbg)
   );
endmodule

// File: rtl/sermem_spi_checker.sv
module sermem_spi_checker #(
   parameter int ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_s,
   input logic              hold_s,
   input logic              ready,
   input logic              so_oe,
   input logic              wel,
   input logic              mem_we,
   input logic [ADDR_W-1:0] addr_q,
   input logic [2:0]        bit_cnt
);
   a_r13_hiz_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s || !hold_s) |-> !so_oe);

   a_r2_silent_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !so_oe);

   a_r4_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wel);

   a_r8_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (addr_q == $past(addr_q) + 1'b1));

   a_r11_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_s && !cs_s) |=> $stable(bit_cnt));

   a_r5_wel_sets_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(!cs_s));
endmodule

bind sermem_spi_slave sermem_spi_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_s   (cs_n_s),
   .hold_s (hold_n_s),
   .ready  (ready),
   .so_oe  (spi_so_oe),
   .wel    (wel_dbg),
   .mem_we (mem_we),
   .addr_q (addr_dbg),
   .bit_cnt(bitcnt_dbg)
);

// File: tb/sermem_spi_slave_bench.sv
module sermem_spi_slave_bench;
   localparam int PWRUP = 600;
   localparam int MAW   = 12;
   localparam int MSZ   = 1 << MAW;
   localparam int H     = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic so, so_oe;

   always #10 clk = ~clk;

   sermem_spi_slave #(.ADDR_W(15), .MEM_AW(MAW), .SYNC_STAGES(2), .PWRUP_CYCLES(PWRUP)) u_sermem_spi_slave (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
      .spi_hold_n(hold_n), .spi_wp_n(wp_n), .spi_so(so), .spi_so_oe(so_oe)
   );

   int   n_run = 0, n_fail = 0;
   bit   done = 1'b0;
   logic [7:0] model [MSZ];
   bit         mvalid [MSZ];
   logic [7:0] wbuf [8];
   bit         m_wel = 0, m_wpen = 0;
   logic [1:0] m_bp = 2'b00;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit prot(input logic [1:0] bp, input logic [14:0] a);
      case (bp)
         2'b01:   return a[14:13] == 2'b11;
         2'b10:   return a[14];
         2'b11:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] exp_status();
      return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame_begin(input bit m3);
      sck = m3;
      wait_clk(3);
      cs_n = 1'b0;
      wait_clk(H);
   endtask

   task automatic frame_end(input bit m3);
      if (!m3) begin
         sck = 1'b0;
         wait_clk(H);
      end
      cs_n = 1'b1;
      wait_clk(2 * H);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         sck = 1'b0;
         si  = tx[i];
         wait_clk(H);
         rx[i] = so;
         sck = 1'b1;
         wait_clk(H);
      end
   endtask

   task automatic send_op(input bit m3, input logic [7:0] op);
      logic [7:0] d;
      frame_begin(m3);
      xfer(op, d);
      frame_end(m3);
      if (op == 8'h06) m_wel = 1;
      if (op == 8'h04) m_wel = 0;
   endtask

   task automatic get_status(input bit m3, output logic [7:0] s, output logic [7:0] s2);
      logic [7:0] d;
      frame_begin(m3);
      xfer(8'h05, d);
      xfer(8'h00, s);
      xfer(8'h00, s2);
      frame_end(m3);
   endtask

   task automatic set_status(input bit m3, input logic [7:0] v);
      logic [7:0] d;
      frame_begin(m3);
      xfer(8'h01, d);
      xfer(v, d);
      frame_end(m3);
      if (m_wel) begin
         if (!(m_wpen && !wp_n)) begin
            m_wpen = v[7];
            m_bp   = v[3:2];
         end
         m_wel = 0;
      end
   endtask

   task automatic write_burst(input bit m3, input logic [15:0] a, input int n);
      logic [7:0]  d;
      logic [14:0] p;
      frame_begin(m3);
      xfer(8'h02, d);
      xfer(a[15:8], d);
      xfer(a[7:0], d);
      for (int i = 0; i < n; i++) begin
         xfer(wbuf[i], d);
         p = a[14:0] + 15'(i);
         if (m_wel && !prot(m_bp, p)) begin
            model[p[MAW-1:0]]  = wbuf[i];
            mvalid[p[MAW-1:0]] = 1;
         end
      end
      frame_end(m3);
      m_wel = 0;
   endtask

   task automatic read_burst(input bit m3, input logic [15:0] a, input int n, input string req);
      logic [7:0]  d;
      logic [14:0] p;
      frame_begin(m3);
      xfer(8'h03, d);
      xfer(a[15:8], d);
      xfer(a[7:0], d);
      for (int i = 0; i < n; i++) begin
         xfer(8'h00, d);
         p = a[14:0] + 15'(i);
         if (mvalid[p[MAW-1:0]]) chk(req, d, model[p[MAW-1:0]]);
      end
      frame_end(m3);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] s, s2, d;
      for (int i = 0; i < MSZ; i++) mvalid[i] = 0;
      void'($urandom(32'h5eed1234));
      wait_clk(4);
      chk("R1 so_oe in reset", {31'd0, so_oe}, 32'd0);
      rst_n = 1'b1;
      wait_clk(2);

      // R2: frames inside the power-up window are ignored
      frame_begin(0);
      xfer(8'h06, d);
      frame_end(0);
      frame_begin(0);
      xfer(8'h05, d);
      chk("R2 so_oe during power-up", {31'd0, so_oe}, 32'd0);
      xfer(8'h00, d);
      frame_end(0);
      wait_clk(PWRUP);
      chk("R13 so_oe with cs high", {31'd0, so_oe}, 32'd0);

      get_status(0, s, s2);
      chk("R1 R2 status after power-up", s, 8'h00);

      send_op(0, 8'h06);
      get_status(1, s, s2);
      chk("R5 wren sets latch", s, 8'h02);
      chk("R6 byte after status", s2, 8'h00);
      send_op(1, 8'h04);
      get_status(0, s, s2);
      chk("R5 wrdi clears latch", s, 8'h00);

      send_op(0, 8'h06);
      wbuf[0] = 8'hA5;
      write_burst(0, 16'h0100, 1);
      read_burst(0, 16'h0100, 1, "R7 basic read");
      get_status(0, s, s2);
      chk("R5 latch cleared after write", s, exp_status());
      wbuf[0] = 8'h5A;
      write_burst(0, 16'h0100, 1);
      frame_begin(0); xfer(8'h03, d); xfer(8'h01, d); xfer(8'h00, d); xfer(8'h00, d); frame_end(0);
      chk("R4 write without latch", d, 8'hA5);

      frame_begin(0); xfer(8'hAB, d); xfer(8'h06, d); frame_end(0);
      get_status(0, s, s2);
      chk("R12 unknown opcode swallows frame", s, 8'h00);

      send_op(0, 8'h06);
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      write_burst(1, 16'h7FFF, 3);
      frame_begin(0); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h00, d);
      chk("R8 wrap to 0x0000", d, 8'h22);
      frame_end(0);
      read_burst(1, 16'h7FFF, 3, "R8 stream across wrap");
      frame_begin(1); xfer(8'h03, d); xfer(8'h80, d); xfer(8'h01, d); xfer(8'h00, d);
      chk("R7 bit 15 ignored", d, 8'h33);
      frame_end(1);
      frame_begin(1); xfer(8'h03, d); xfer(8'h01, d); xfer(8'h00, d); xfer(8'h00, d);
      chk("R3 mode 3 msb-first read", d, 8'hA5);
      frame_end(1);

      // R11 hold in the middle of a read burst
      send_op(0, 8'h06);
      wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
      write_burst(0, 16'h0200, 4);
      frame_begin(0);
      xfer(8'h03, d); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h00, d);
      chk("R11 byte before hold", d, 8'h01);
      hold_n = 1'b0;
      wait_clk(H);
      chk("R11 so_oe during hold", {31'd0, so_oe}, 32'd0);
      for (int k = 0; k < 3; k++) begin
         sck = 1'b0; wait_clk(H);
         sck = 1'b1; wait_clk(H);
      end
      hold_n = 1'b1;
      wait_clk(H);
      xfer(8'h00, d);
      chk("R11 byte after hold", d, 8'h02);
      frame_end(0);

      // R9 block protection
      send_op(0, 8'h06);
      wbuf[0] = 8'h10; write_burst(0, 16'h6123, 1);
      send_op(0, 8'h06);
      wbuf[0] = 8'h20; write_burst(0, 16'h4456, 1);
      send_op(0, 8'h06);
      set_status(0, 8'h04);
      get_status(0, s, s2);
      chk("R6 R9 status after protect field 01", s, 8'h04);
      send_op(0, 8'h06); wbuf[0] = 8'h77; write_burst(0, 16'h6123, 1);
      send_op(0, 8'h06); wbuf[0] = 8'h88; write_burst(0, 16'h4456, 1);
      read_burst(0, 16'h6123, 1, "R9 top quarter locked");
      read_burst(0, 16'h4456, 1, "R9 below top quarter writable");
      send_op(0, 8'h06); set_status(0, 8'h08);
      send_op(0, 8'h06); wbuf[0] = 8'h99; write_burst(0, 16'h4456, 1);
      read_burst(0, 16'h4456, 1, "R9 top half locked");
      send_op(0, 8'h06); set_status(0, 8'h0C);
      send_op(0, 8'h06); wbuf[0] = 8'h66; wbuf[1] = 8'h67; write_burst(0, 16'h00FF, 2);
      read_burst(0, 16'h0100, 1, "R9 whole array locked");
      send_op(0, 8'h06); set_status(0, 8'h00);

      // R10 write-protect pin
      send_op(0, 8'h06); set_status(0, 8'h80);
      wp_n = 1'b0;
      send_op(0, 8'h06); set_status(0, 8'h0C);
      get_status(0, s, s2);
      chk("R10 status locked by pin", s, 8'h80);
      wp_n = 1'b1;
      send_op(0, 8'h06); set_status(0, 8'h00);
      get_status(0, s, s2);
      chk("R10 status writable with pin high", s, 8'h00);

      // R3 R8 random streams
      for (int it = 0; it < 24; it++) begin
         bit          m3 = 1'($urandom);
         logic [15:0] a  = 16'($urandom);
         int          n  = 1 + int'($urandom % 5);
         for (int j = 0; j < n; j++) wbuf[j] = 8'($urandom);
         if (($urandom % 4) != 0) send_op(m3, 8'h06);
         write_burst(m3, a, n);
         read_burst(!m3, a, n, "R3 R8 random stream");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule